// File: doc/BRIEF.md
# Banked ROM/RAM Mapper with Banking Mode

This block maps a large cartridge ROM and a small banked external RAM into the address space of an 8-bit CPU with a 16-bit address bus. CPU writes that land in the lower 32 KB cannot change ROM contents, so the block treats them as writes to four control registers. Address bits 15:13 select the register. From these registers it forms the bank number for the switchable ROM window, the external RAM bank number and a RAM enable flag. The ROM and RAM arrays and their read paths sit outside the block and only use its bank outputs.

A mode bit decides what a 2-bit register does. In mode 0 it supplies ROM bank bits 6:5. In mode 1 it selects the RAM bank. A zero in the 5-bit low ROM bank field is always replaced by one before the upper bits are joined to it. The joined bank number is then masked to the ROM size. The ROM size is a power-of-two count of 16 KB banks. The block drives a RAM chip select for CPU accesses to the RAM window, but only while RAM is enabled.

Top module: `mbmap_top`

## Requirements
- R1: After a synchronous reset, rom_bank is 1 (masked to the ROM size), ram_bank is 0, mode is 0 and ram_en is 0.
- R2: A write in region 0 (addr 0x0000–0x1FFF) with data 0x0A sets ram_en. Data 0x00 clears it. Any other data leaves ram_en unchanged.
- R3: A write in region 1 (0x2000–0x3FFF) loads data[4:0] into ROM bank bits 4:0, with 0 replaced by 1. ROM bank bits 6:5 are kept.
- R4: A write in region 2 (0x4000–0x5FFF) while mode is 0 loads data[1:0] into ROM bank bits 6:5. The RAM bank stays 0.
- R5: A write in region 2 while mode is 1 loads data[1:0] into ram_bank. The ROM bank is unchanged.
- R6: A write in region 3 (0x6000–0x7FFF) sets mode to data[0]. Writing 1 clears ROM bank bits 6:5. Writing 0 forces ram_bank to 0.
- R7: The rom_bank output is the composed bank number ANDed with (ROM_BANKS − 1).
- R8: ram_cs is 1 exactly when cpu_req is 1, ram_en is 1 and cpu_addr is in 0xA000–0xBFFF. It follows the inputs in the same cycle.
- R9: Writes with cpu_addr[15] = 1 change no register and no output.
- R10: Register updates take effect on the clock edge that samples the write. The outputs show the new state from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one per cycle |
| cpu_req | input | 1 | CPU access (read or write) in progress |
| rom_bank | output | 7 | Effective bank for the switchable ROM window |
| ram_bank | output | 2 | External RAM bank |
| ram_en | output | 1 | RAM enable flag |
| ram_cs | output | 1 | RAM chip select |

## Verification
The interesting coincidences are zero-bank remapping together with size masking, and a mode change together with the clearing of the upper bits. A bench model tracks the raw register values as integers. It writes zero to the low field while the upper bits are non-zero and the ROM is set to 64 banks. In that cycle both remapping and masking act on the same output. It also switches mode while the 2-bit register holds a non-zero value, so that the clearing and the mode move land together. Every cycle, all four outputs are compared against the model.

// File: rtl/mbmap_pkg.sv
package mbmap_pkg;
  localparam int LO_W    = 5;
  localparam int HI_W    = 2;
  localparam int ROM_BW  = LO_W + HI_W;
  localparam int RAM_BW  = 2;
  localparam int NREGION = 4;

  typedef enum logic [1:0] {
    RG_RAMGATE = 2'd0,
    RG_BANKLO  = 2'd1,
    RG_SHARED  = 2'd2,
    RG_MODE    = 2'd3
  } region_e;

  localparam logic [7:0] GATE_ON  = 8'h0A;
  localparam logic [7:0] GATE_OFF = 8'h00;
endpackage

// File: rtl/mbmap_decode.sv
module mbmap_decode
  import mbmap_pkg::*;
(
  input  logic [15:0]        cpu_addr,
  input  logic               cpu_wr,
  output logic [NREGION-1:0] reg_we
);
  logic ctl_space;
  assign ctl_space = cpu_wr && !cpu_addr[15];

  for (genvar g = 0; g < NREGION; g++) begin : g_strobe
    assign reg_we[g] = ctl_space && (cpu_addr[14:13] == 2'(g));
  end
endmodule

// File: rtl/mbmap_regs.sv
module mbmap_regs
  import mbmap_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NREGION-1:0] reg_we,
  input  logic [7:0]         wdata,
  output logic [LO_W-1:0]    lo_q,
  output logic [HI_W-1:0]    hi_q,
  output logic               mode_q,
  output logic [RAM_BW-1:0]  rambank_q,
  output logic               gate_q
);
  logic [LO_W-1:0] lo_in;
  assign lo_in = (wdata[LO_W-1:0] == '0) ? LO_W'(1) : wdata[LO_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q      <= LO_W'(1);
      hi_q      <= '0;
      mode_q    <= 1'b0;
      rambank_q <= '0;
      gate_q    <= 1'b0;
    end else begin
      if (reg_we[RG_RAMGATE]) begin
        if (wdata == GATE_ON)       gate_q <= 1'b1;
        else if (wdata == GATE_OFF) gate_q <= 1'b0;
      end
      if (reg_we[RG_BANKLO]) lo_q <= lo_in;
      if (reg_we[RG_SHARED]) begin
        if (mode_q) rambank_q <= wdata[RAM_BW-1:0];
        else        hi_q      <= wdata[HI_W-1:0];
      end
      if (reg_we[RG_MODE]) begin
        mode_q <= wdata[0];
        if (wdata[0]) hi_q      <= '0;
        else          rambank_q <= '0;
      end
    end
  end

  // R3: the low field can never hold zero
  a_r3_lo_nonzero: assert property (@(posedge clk) disable iff (rst)
    lo_q != '0);
  // R2: enable value opens the RAM gate on the next cycle
  a_r2_gate_on: assert property (@(posedge clk) disable iff (rst)
    (reg_we[RG_RAMGATE] && wdata == GATE_ON) |=> gate_q);
  // R6: entering mode 1 leaves the upper ROM bits cleared
  a_r6_mode_set: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_q) |-> (hi_q == '0));
  // R4: in mode 0 the RAM bank stays 0
  a_r4_mode0_ram: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> (rambank_q == '0));
  // R9: writes above the lower 32 KB leave all state alone
  a_r9_no_strobe_stable: assert property (@(posedge clk) disable iff (rst)
    (reg_we == '0) |=> ($stable(lo_q) && $stable(hi_q) && $stable(mode_q)
                        && $stable(rambank_q) && $stable(gate_q)));
endmodule

// File: rtl/mbmap_compose.sv
module mbmap_compose
  import mbmap_pkg::*;
#(
  parameter int ROM_BANKS = 128
) (
  input  logic [LO_W-1:0]   lo,
  input  logic [HI_W-1:0]   hi,
  output logic [ROM_BW-1:0] bank
);
  localparam logic [ROM_BW-1:0] MASK = ROM_BW'(ROM_BANKS - 1);
  assign bank = {hi, lo} & MASK;
endmodule

// File: rtl/mbmap_top.sv
module mbmap_top
  import mbmap_pkg::*;
#(
  parameter int ROM_BANKS = 128
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  input  logic        cpu_wr,
  input  logic        cpu_req,
  output logic [6:0]  rom_bank,
  output logic [1:0]  ram_bank,
  output logic        ram_en,
  output logic        ram_cs
);
  logic [NREGION-1:0] reg_we;
  logic [LO_W-1:0]    lo_q;
  logic [HI_W-1:0]    hi_q;
  logic               mode_q;

  mbmap_decode u_dec (
    .cpu_addr (cpu_addr),
    .cpu_wr   (cpu_wr),
    .reg_we   (reg_we)
  );

  mbmap_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .wdata     (cpu_data),
    .lo_q      (lo_q),
    .hi_q      (hi_q),
    .mode_q    (mode_q),
    .rambank_q (ram_bank),
    .gate_q    (ram_en)
  );

  mbmap_compose #(.ROM_BANKS(ROM_BANKS)) u_cmp (
    .lo   (lo_q),
    .hi   (hi_q),
    .bank (rom_bank)
  );

  assign ram_cs = cpu_req && ram_en && (cpu_addr[15:13] == 3'b101);

  // R7: effective bank never reaches beyond the ROM
  a_r7_in_range: assert property (@(posedge clk) disable iff (rst)
    int'(rom_bank) < ROM_BANKS);
  // R8: chip select never fires while RAM is gated off
  a_r8_cs_gated: assert property (@(posedge clk) disable iff (rst)
    !ram_en |-> !ram_cs);
endmodule

// File: tb/mbmap_top_test.sv
`timescale 1ns/1ps
module mbmap_top_test;
  localparam int NB = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_req = 1'b0;
  logic [6:0]  rom_bank;
  logic [1:0]  ram_bank;
  logic        ram_en, ram_cs;

  int compared = 0, mismatched = 0;
  bit done = 0;
  int m_lo, m_hi, m_mode, m_rb, m_en;

  always #10 clk = ~clk;

  mbmap_top #(.ROM_BANKS(NB)) uut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .cpu_req(cpu_req), .rom_bank(rom_bank),
    .ram_bank(ram_bank), .ram_en(ram_en), .ram_cs(ram_cs)
  );

  task automatic model_reset();
    m_lo = 1; m_hi = 0; m_mode = 0; m_rb = 0; m_en = 0;
  endtask

  task automatic model_write(input int a, input int d);
    if (a < 16'h8000) begin
      case (a / 16'h2000)
        0: if (d == 8'h0A) m_en = 1; else if (d == 0) m_en = 0;
        1: m_lo = ((d % 32) == 0) ? 1 : (d % 32);
        2: if (m_mode == 1) m_rb = d % 4; else m_hi = d % 4;
        default: begin
          m_mode = d % 2;
          if (m_mode == 1) m_hi = 0; else m_rb = 0;
        end
      endcase
    end
  endtask

  task automatic check(input string tag);
    int exp_rom, exp_cs;
    exp_rom = (m_hi * 32 + m_lo) % NB;
    exp_cs  = (cpu_req && m_en && cpu_addr >= 16'hA000 && cpu_addr <= 16'hBFFF) ? 1 : 0;
    compared++;
    if (int'(rom_bank) != exp_rom || int'(ram_bank) != m_rb ||
        int'(ram_en) != m_en || int'(ram_cs) != exp_cs) begin
      mismatched++;
      $display("FAIL %s: rom=%0d ram=%0d en=%0d cs=%0d expected rom=%0d ram=%0d en=%0d cs=%0d",
               tag, rom_bank, ram_bank, ram_en, ram_cs, exp_rom, m_rb, m_en, exp_cs);
    end
  endtask

  // one cycle: drive at negedge, model updates at posedge, compare at next negedge
  task automatic cyc(input bit wr, input bit req, input int a, input int d, input string tag);
    cpu_wr = wr; cpu_req = req; cpu_addr = 16'(a); cpu_data = 8'(d);
    @(posedge clk);
    if (rst) model_reset(); else if (wr) model_write(a, d);
    @(negedge clk);
    check(tag);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 100000);
    mismatched++;
    $display("FAIL watchdog: expired, expected completion");
    finish_up();
  end

  initial begin
    model_reset();
    @(negedge clk);
    cyc(0, 0, 0, 0, "R1 reset");
    cyc(0, 0, 0, 0, "R1 reset");
    rst = 0;
    cyc(0, 0, 0, 0, "R1 after reset");
    cyc(0, 1, 16'hA123, 0, "R8 cs gated off");
    cyc(1, 1, 16'h0000, 8'h0A, "R2 enable");
    cyc(0, 1, 16'hA000, 0, "R8 cs low edge");
    cyc(0, 1, 16'hBFFF, 0, "R8 cs high edge");
    cyc(0, 1, 16'hC000, 0, "R8 cs outside");
    cyc(0, 0, 16'hB000, 0, "R8 no request");
    cyc(1, 1, 16'h1FFF, 8'h55, "R2 other value ignored");
    cyc(1, 1, 16'h2000, 8'h13, "R3 low bank");
    cyc(1, 1, 16'h4000, 8'h03, "R4 hi bits mode0");
    cyc(1, 1, 16'h2abc, 8'hE0, "R3 zero remap with hi kept");
    cyc(1, 1, 16'h3FFF, 8'h1F, "R7 mask top bit");
    cyc(1, 1, 16'hA000, 8'h00, "R9 ram-area write ignored");
    cyc(1, 1, 16'hE000, 8'h01, "R9 high write ignored");
    cyc(1, 1, 16'h6000, 8'h01, "R6 mode1 clears hi");
    cyc(1, 1, 16'h5000, 8'h02, "R5 ram bank mode1");
    cyc(1, 1, 16'h4000, 8'h07, "R5 ram bank wraps 2 bits");
    cyc(1, 1, 16'h7FFF, 8'hFE, "R6 mode0 clears ram bank");
    cyc(1, 1, 16'h4000, 8'h01, "R4 hi bits after return");
    cyc(1, 1, 16'h2000, 8'h20, "R3 masked zero remap");
    cyc(1, 1, 16'h0001, 8'h00, "R2 disable");
    cyc(0, 1, 16'hA800, 0, "R8 cs after disable");
    for (int i = 0; i < 40; i++)
      cyc(1, 1, (i * 16'h1357) % 16'h8000, (i * 37) % 256, "R10 sweep");
    rst = 1;
    cyc(0, 0, 0, 0, "R1 reset again");
    rst = 0;
    cyc(0, 0, 0, 0, "R1 post second reset");
    finish_up();
  end
endmodule